// File: doc/BRIEF.md
# Two-Stage Pipelined Saturating MAC

This block multiplies two signed N-bit operands and adds the product into a wide signed accumulator on every cycle in which its operands are valid. It has a fixed two-cycle latency. The first stage forms the partial products and compresses them in a carry-save tree. It registers the unresolved sum and carry vectors, not a finished product. The second stage adds a constant sign correction and the previous accumulator value in carry-save form, then performs a single carry-propagate addition into the accumulator register.

The accumulator is 2N+G bits wide. The G guard bits let long runs of products leave and re-enter the 2N-bit range without loss. Two read-out paths are provided: the full guarded value, and a 2N-bit value clamped to the most positive or most negative 2N-bit number, with a flag raised while clamping is in effect. A clear request travels down the pipeline with the operands, so that it takes effect in order with them.

Top module: `pipe_mac`

## Requirements
- R1: With `clear_i` and `valid_i` high, the accumulator becomes exactly the signed product `a_i * b_i`, for all operand values including the most negative value (two's complement).
- R2: Operands sampled at clock edge k change `acc_full_o` only at edge k+1. `valid_o` rises after edge k+1 and stays low after edge k.
- R3: With `valid_i` high and `clear_i` low, the accumulator becomes its previous value plus `a_i * b_i`.
- R4: A clear sampled together with valid operands discards the old accumulator value, so the new value is the product alone.
- R5: A clear sampled with `valid_i` low leaves `acc_full_o` unchanged after the next edge and sets it to zero after the edge after that. `valid_o` stays low.
- R6: While `valid_i` and `clear_i` are low, `acc_full_o` holds whatever values the operand inputs take, and `valid_o` is low.
- R7: `acc_full_o` carries the exact sum in 2N+G bits, so a sum beyond the 2N-bit range that later returns inside it reads back exactly.
- R8: When the accumulator is above 2^(2N-1)-1, `acc_sat_o` is 2^(2N-1)-1 and `ovf_o` is 1.
- R9: When the accumulator is below -2^(2N-1), `acc_sat_o` is -2^(2N-1) (only the top bit set) and `ovf_o` is 1.
- R10: When the accumulator lies in the 2N-bit signed range, `acc_sat_o` equals its low 2N bits and `ovf_o` is 0.
- R11: After reset, `acc_full_o`, `acc_sat_o`, `ovf_o` and `valid_o` are all zero.
- R12: Operands presented on consecutive cycles are each accumulated, and one result appears per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| clear_i | input | 1 | Discard the accumulator (product alone if valid, zero otherwise) |
| a_i | input | N | Signed multiplicand |
| b_i | input | N | Signed multiplier |
| valid_o | output | 1 | Accumulator updated by a product on the last edge |
| acc_full_o | output | 2N+G | Full guarded accumulator, signed |
| acc_sat_o | output | 2N | Accumulator clamped to the 2N-bit signed range |
| ovf_o | output | 1 | Clamping in effect on acc_sat_o |

## Verification
The hardest states to reach are those where the accumulator lies outside the 2N-bit range. No single product can get there, because the largest product magnitude is 2^(2N-2). The stimulus therefore chains products of the extreme operand values, starting from a clear. It pushes the sum past the positive limit and on to 2^(2N) inside the guard bits, then drives it back into range with negative products and checks the exact value. A separate chain drives the sum below the negative limit. A back-to-back stream with a clear at its head exercises the pipelined path, in which each stage-2 merge uses the accumulator value written on the previous cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // rows left after one layer of 3:2 compression
  function automatic int rows_next(int rows);
    return 2 * (rows / 3) + rows % 3;
  endfunction

  function automatic int rows_after(int rows, int lvl);
    int c;
    c = rows;
    for (int i = 0; i < lvl; i++) c = rows_next(c);
    return c;
  endfunction

  function automatic int tree_depth(int rows);
    int c;
    int d;
    c = rows;
    d = 0;
    while (c > 2) begin
      c = rows_next(c);
      d++;
    end
    return d;
  endfunction
endpackage

// File: rtl/mac_csa.sv
module mac_csa #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] maj;

  assign s_o = x_i ^ y_i ^ z_i;
  assign maj = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign c_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/mac_pp_gen.sv
// Rows are non-negative. Each signed row is offset by +2^(N-1) (sign bit
// inverted). The offsets are removed by one constant added in stage 2.
module mac_pp_gen #(
  parameter int N = 16,
  parameter int W = 2 * N + 1
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [W-1:0] rows_o [N+1]
);
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] x;
    if (i == N - 1) begin : g_neg
      // -b*a = b*(~a) + b
      assign x = b_i[i] ? ~a_i : '0;
    end else begin : g_pos
      assign x = b_i[i] ? a_i : '0;
    end
    assign rows_o[i] = W'({~x[N-1], x[N-2:0]}) << i;
  end

  // +b for the negated top row
  assign rows_o[N] = W'(b_i[N-1]) << (N - 1);
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
  parameter int W    = 33,
  parameter int ROWS = 17
) (
  input  logic [W-1:0] rows_i [ROWS],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  localparam int LEVELS = mac_pkg::tree_depth(ROWS);

  logic [W-1:0] v [LEVELS+1][ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_in
    assign v[0][r] = rows_i[r];
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CIN = mac_pkg::rows_after(ROWS, l);
    localparam int NG  = CIN / 3;
    localparam int REM = CIN % 3;

    for (genvar g = 0; g < NG; g++) begin : g_csa
      mac_csa #(.W(W)) u_csa (
        .x_i(v[l][3*g]),
        .y_i(v[l][3*g+1]),
        .z_i(v[l][3*g+2]),
        .s_o(v[l+1][2*g]),
        .c_o(v[l+1][2*g+1])
      );
    end

    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign v[l+1][2*NG+r] = v[l][3*NG+r];
    end

    for (genvar z = 2 * NG + REM; z < ROWS; z++) begin : g_zero
      assign v[l+1][z] = '0;
    end
  end

  assign sum_o   = v[LEVELS][0];
  assign carry_o = v[LEVELS][1];
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int AW = 40,
  parameter int OW = 32
) (
  input  logic [AW-1:0] acc_i,
  output logic [OW-1:0] sat_o,
  output logic          ovf_o
);
  localparam int HW = AW - OW + 1;
  localparam logic [OW-1:0] POS_MAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] NEG_MIN = {1'b1, {(OW-1){1'b0}}};

  logic [HW-1:0] head;
  logic          fits;

  assign head  = acc_i[AW-1:OW-1];
  assign fits  = (&head) | (~|head);
  assign ovf_o = ~fits;

  always_comb begin
    if (fits)              sat_o = acc_i[OW-1:0];
    else if (acc_i[AW-1])  sat_o = NEG_MIN;
    else                   sat_o = POS_MAX;
  end
endmodule

// File: rtl/pipe_mac.sv
module pipe_mac #(
  parameter int N = 16,
  parameter int G = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clear_i,
  input  logic [N-1:0]      a_i,
  input  logic [N-1:0]      b_i,
  output logic              valid_o,
  output logic [2*N+G-1:0]  acc_full_o,
  output logic [2*N-1:0]    acc_sat_o,
  output logic              ovf_o
);
  localparam int PW   = 2 * N;
  localparam int W1   = PW + 1;
  localparam int AW   = PW + G;
  localparam int ROWS = N + 1;

  // removes the N row offsets of 2^(N-1) * 2^i
  localparam logic [AW-1:0] ONES_N = {{(AW-N){1'b0}}, {N{1'b1}}};
  localparam logic [AW-1:0] CORR   = ~(ONES_N << (N - 1)) + {{(AW-1){1'b0}}, 1'b1};

  // ---------------- stage 1 ----------------
  logic [W1-1:0] rows [ROWS];
  logic [W1-1:0] tree_sum, tree_carry;
  logic [W1-1:0] s1_sum_q, s1_carry_q;
  logic          s1_vld_q, s1_clr_q;

  mac_pp_gen #(.N(N), .W(W1)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .rows_o(rows)
  );

  mac_csa_tree #(.W(W1), .ROWS(ROWS)) u_tree (
    .rows_i (rows),
    .sum_o  (tree_sum),
    .carry_o(tree_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_sum_q   <= '0;
      s1_carry_q <= '0;
      s1_vld_q   <= 1'b0;
      s1_clr_q   <= 1'b0;
    end else begin
      s1_vld_q <= valid_i;
      s1_clr_q <= clear_i;
      if (valid_i) begin
        s1_sum_q   <= tree_sum;
        s1_carry_q <= tree_carry;
      end
    end
  end

  // ---------------- stage 2 ----------------
  logic [AW-1:0] acc_q, acc_base, acc_d;
  logic [AW-1:0] m1_s, m1_c, m2_s, m2_c;
  logic          vld_q;

  assign acc_base = s1_clr_q ? '0 : acc_q;

  mac_csa #(.W(AW)) u_merge_corr (
    .x_i(AW'(s1_sum_q)),
    .y_i(AW'(s1_carry_q)),
    .z_i(CORR),
    .s_o(m1_s),
    .c_o(m1_c)
  );

  mac_csa #(.W(AW)) u_merge_acc (
    .x_i(m1_s),
    .y_i(m1_c),
    .z_i(acc_base),
    .s_o(m2_s),
    .c_o(m2_c)
  );

  assign acc_d = m2_s + m2_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= s1_vld_q;
      if (s1_vld_q)      acc_q <= acc_d;
      else if (s1_clr_q) acc_q <= '0;
    end
  end

  mac_sat #(.AW(AW), .OW(PW)) u_sat (
    .acc_i(acc_q),
    .sat_o(acc_sat_o),
    .ovf_o(ovf_o)
  );

  assign acc_full_o = acc_q;
  assign valid_o    = vld_q;
endmodule

// File: rtl/pipe_mac_chk.sv
module pipe_mac_chk #(
  parameter int N = 16,
  parameter int G = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              clear_i,
  input logic              valid_o,
  input logic [2*N+G-1:0]  acc_full_o,
  input logic [2*N-1:0]    acc_sat_o,
  input logic              ovf_o
);
  localparam int PW = 2 * N;
  localparam int AW = PW + G;

  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age == 2'd2) && $past(!valid_i && !clear_i, 2)) |-> $stable(acc_full_o));

  // R5
  lone_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age == 2'd2) && $past(clear_i && !valid_i, 2)) |-> (acc_full_o == '0));

  // R8
  pos_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !acc_full_o[AW-1]) |-> (acc_sat_o == {1'b0, {(PW-1){1'b1}}}));

  // R9
  neg_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && acc_full_o[AW-1]) |-> (acc_sat_o == {1'b1, {(PW-1){1'b0}}}));

  // R10
  in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |-> (acc_sat_o == acc_full_o[PW-1:0]));
endmodule

bind pipe_mac pipe_mac_chk #(.N(N), .G(G)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .clear_i   (clear_i),
  .valid_o   (valid_o),
  .acc_full_o(acc_full_o),
  .acc_sat_o (acc_sat_o),
  .ovf_o     (ovf_o)
);

// File: tb/pipe_mac_bench.sv
`timescale 1ns/1ps
module pipe_mac_bench;
  localparam int N  = 16;
  localparam int G  = 8;
  localparam int AW = 2 * N + G;
  localparam int PW = 2 * N;

  typedef struct packed {
    logic [N-1:0]         a;
    logic [N-1:0]         b;
    logic                 clr;
    logic signed [AW-1:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{a: 16'd3,     b: 16'd5,     clr: 1'b1, exp: 40'sd15},
    '{a: 16'hFFF9,  b: 16'd6,     clr: 1'b0, exp: -40'sd27},
    '{a: 16'h8000,  b: 16'h8000,  clr: 1'b0, exp: 40'sd1073741797},
    '{a: 16'h7FFF,  b: 16'h8000,  clr: 1'b0, exp: 40'sd32741},
    '{a: 16'hFFFF,  b: 16'hFFFF,  clr: 1'b0, exp: 40'sd32742},
    '{a: 16'd0,     b: 16'd12345, clr: 1'b0, exp: 40'sd32742},
    '{a: 16'd100,   b: 16'hFF9C,  clr: 1'b1, exp: -40'sd10000},
    '{a: 16'h8000,  b: 16'h7FFF,  clr: 1'b0, exp: -40'sd1073719056}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic          clear = 1'b0;
  logic [N-1:0]  a = '0;
  logic [N-1:0]  b = '0;
  logic          valid_o;
  logic [AW-1:0] acc_full;
  logic [PW-1:0] acc_sat;
  logic          ovf;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  pipe_mac #(.N(N), .G(G)) u_pipe_mac (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid),
    .clear_i   (clear),
    .a_i       (a),
    .b_i       (b),
    .valid_o   (valid_o),
    .acc_full_o(acc_full),
    .acc_sat_o (acc_sat),
    .ovf_o     (ovf)
  );

  function automatic longint full_v();
    return longint'($signed(acc_full));
  endfunction

  function automatic longint sat_v();
    return longint'($signed(acc_sat));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one operation, then idle until the result is visible
  task automatic run_op(input logic [N-1:0] av, input logic [N-1:0] bv, input logic cl);
    @(negedge clk);
    a = av; b = bv; clear = cl; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; clear = 1'b0;
    @(negedge clk);
  endtask

  longint prev;
  longint cum [4];

  initial begin
    // R11 reset state
    #1;
    chk(full_v() == 0, "R11 full", full_v(), 0);
    chk(acc_sat == '0 && !ovf && !valid_o, "R11 sat/ovf/valid", sat_v(), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full_v() == 0 && !valid_o, "R11 after release", full_v(), 0);

    // table walk: R1, R2, R3, R4, R10
    prev = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      a = VECS[i].a; b = VECS[i].b; clear = VECS[i].clr; valid = 1'b1;
      @(negedge clk);
      valid = 1'b0; clear = 1'b0;
      chk(full_v() == prev && !valid_o, "R2 no change after first edge", full_v(), prev);
      @(negedge clk);
      chk(full_v() == longint'(VECS[i].exp),
          VECS[i].clr ? "R1 R4 product after clear" : "R3 accumulate",
          full_v(), longint'(VECS[i].exp));
      chk(valid_o, "R2 valid_o after second edge", longint'(valid_o), 1);
      chk(!ovf && sat_v() == longint'(VECS[i].exp), "R10 in-range read-out", sat_v(),
          longint'(VECS[i].exp));
      prev = longint'(VECS[i].exp);
    end

    // positive clamp, guard bits: R8, R7
    run_op(16'h8000, 16'h8000, 1'b1);
    chk(full_v() == 64'sd1073741824, "R1 largest product", full_v(), 64'sd1073741824);
    run_op(16'h8000, 16'h8000, 1'b0);
    chk(full_v() == 64'sd2147483648, "R7 full beyond range", full_v(), 64'sd2147483648);
    chk(ovf && acc_sat == 32'h7FFFFFFF, "R8 positive clamp", sat_v(), 64'sd2147483647);
    run_op(16'h8000, 16'h8000, 1'b0);
    run_op(16'h8000, 16'h8000, 1'b0);
    chk(full_v() == 64'sd4294967296, "R7 guard bits", full_v(), 64'sd4294967296);
    chk(ovf && acc_sat == 32'h7FFFFFFF, "R8 clamp deep", sat_v(), 64'sd2147483647);
    for (int k = 0; k < 4; k++) run_op(16'h8000, 16'h7FFF, 1'b0);
    chk(full_v() == 64'sd131072, "R7 exact return", full_v(), 64'sd131072);
    chk(!ovf && sat_v() == 64'sd131072, "R10 back in range", sat_v(), 64'sd131072);

    // negative clamp: R9
    run_op(16'h8000, 16'h7FFF, 1'b1);
    run_op(16'h8000, 16'h7FFF, 1'b0);
    chk(!ovf && sat_v() == -64'sd2147418112, "R10 near negative limit", sat_v(), -64'sd2147418112);
    run_op(16'h8000, 16'h7FFF, 1'b0);
    chk(full_v() == -64'sd3221127168, "R7 negative beyond range", full_v(), -64'sd3221127168);
    chk(ovf && acc_sat == 32'h80000000, "R9 negative clamp", sat_v(), -64'sd2147483648);

    // idle with changing operands: R6
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a = 16'h1234 + 16'(k); b = 16'hFEDC - 16'(k);
      chk(full_v() == -64'sd3221127168 && !valid_o, "R6 hold while idle",
          full_v(), -64'sd3221127168);
    end
    @(negedge clk);
    chk(full_v() == -64'sd3221127168 && !valid_o, "R6 hold after idle",
        full_v(), -64'sd3221127168);

    // lone clear: R5
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(full_v() == -64'sd3221127168, "R5 not yet cleared", full_v(), -64'sd3221127168);
    @(negedge clk);
    chk(full_v() == 0 && !valid_o && !ovf, "R5 cleared", full_v(), 0);

    // back-to-back stream: R12
    cum[0] = 6; cum[1] = 26; cum[2] = 5; cum[3] = 105;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        chk(full_v() == cum[n-2], "R12 streamed result", full_v(), cum[n-2]);
        chk(valid_o, "R12 valid per cycle", longint'(valid_o), 1);
      end
      case (n)
        0: begin a = 16'd2;    b = 16'd3;  clear = 1'b1; valid = 1'b1; end
        1: begin a = 16'd4;    b = 16'd5;  clear = 1'b0; valid = 1'b1; end
        2: begin a = 16'hFFFD; b = 16'd7;  clear = 1'b0; valid = 1'b1; end
        3: begin a = 16'd10;   b = 16'd10; clear = 1'b0; valid = 1'b1; end
        default: begin valid = 1'b0; clear = 1'b0; end
      endcase
    end
    @(negedge clk);
    chk(!valid_o && full_v() == 105, "R12 stream end", full_v(), 105);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule